// File: doc/BRIEF.md
# Serial FIFO Status and Interrupt Unit

This block sits between a host register interface and the shift logic of a synchronous serial port. It holds one transmit queue and one receive queue, each 16 words of 17 bits. The host writes words into the transmit queue and reads words from the receive queue. The serial engine takes words from the transmit queue and deposits words it has collected into the receive queue.

Around the two queues the block keeps occupancy counts and two threshold flags whose levels are chosen by 2-bit codes. It also keeps two sticky error flags, one for a transmit queue that runs dry (underrun) and one for a receive queue that overflows (overrun). From these four sources it builds a single interrupt request and a pair of DMA requests. Software flushes each queue with its own control and clears the error flags by writing zeros.

A unit enable gates only the engine side. Dropping it leaves the queue contents untouched. The block also hands a loopback select to the shift logic.

Top module: `sfs_unit`

## Requirements
- R1: Each queue keeps first-in first-out order, holds up to 16 words of 17 bits, and reports its occupancy (0 to 16) on a 5-bit count. `tx_full` is high at 16 and `rx_empty` is high at 0. A host write to a full transmit queue is dropped, unless an engine read in the same cycle frees a slot.
- R2: `tx_thr_flag` is high while the transmit count is at or below the level picked by `tx_thr_code`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. Software normally programs 2'b10.
- R3: `rx_thr_flag` is high while the receive count is at or above the level picked by `rx_thr_code`, using the same code table as R2. Software normally programs 2'b01.
- R4: An enabled engine read from an empty transmit queue sets `undr_flag`. An enabled engine write into a full receive queue sets `ovr_flag`, provided there is no host read or receive flush in the same cycle, and the word is discarded. Both flags hold until cleared.
- R5: A pulse on `err_clr_wr` clears `ovr_flag` when `err_clr_data[0]` is 0 and clears `undr_flag` when `err_clr_data[1]` is 0. A 1 in either bit leaves that flag as it is. A set in the same cycle wins over a clear.
- R6: `irq` is the OR of the four sources (transmit threshold, receive threshold, underrun, overrun), each masked by its own enable.
- R7: `dma_tx_req` equals `tx_thr_flag` when `dma_en` is 1 and `ie_tx_thr` is 0, and is 0 otherwise. `dma_rx_req` follows the same rule using `rx_thr_flag` and `ie_rx_thr`. The error flags never raise a DMA request.
- R8: After reset both counts are 0, `tx_thr_flag` and `rx_empty` are 1, `rx_thr_flag` and both error flags are 0, and `end_flag` is 1 while `eng_busy` is low.
- R9: `tx_flush` and `rx_flush` empty their queue at the next clock edge and override any push or pop in the same cycle. While `unit_en` is 0, engine reads and writes are ignored and neither error flag is set, while the stored words and host accesses are unaffected.
- R10: A host read from an empty receive queue leaves the count at 0, and `host_rdata` reads 0 whenever the receive queue is empty. `eng_tx_data` likewise reads 0 when the transmit queue is empty.
- R11: `end_flag` is the inverse of `eng_busy`, and `loop_en` is `loop_cfg` gated by `unit_en`.
- R12: On a full receive queue, a host read together with an engine write completes both, and the count stays at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Enables the engine-side ports |
| loop_cfg | input | 1 | Loopback select requested by software |
| host_push | input | 1 | Write `host_wdata` into the transmit queue |
| host_wdata | input | 17 | Transmit word |
| host_pop | input | 1 | Remove the head of the receive queue |
| host_rdata | output | 17 | Head of the receive queue, 0 when empty |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| err_clr_wr | input | 1 | Error-flag clear strobe |
| err_clr_data | input | 2 | Bit 0 for overrun, bit 1 for underrun; 0 clears |
| tx_thr_code | input | 2 | Transmit threshold code |
| rx_thr_code | input | 2 | Receive threshold code |
| ie_tx_thr | input | 1 | Interrupt enable, transmit threshold |
| ie_rx_thr | input | 1 | Interrupt enable, receive threshold |
| ie_undr | input | 1 | Interrupt enable, underrun |
| ie_ovr | input | 1 | Interrupt enable, overrun |
| dma_en | input | 1 | DMA enable |
| eng_busy | input | 1 | Engine is mid-transfer |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 17 | Transmit head, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers `eng_rx_data` |
| eng_rx_data | input | 17 | Received word |
| tx_count | output | 5 | Transmit occupancy |
| rx_count | output | 5 | Receive occupancy |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_thr_flag | output | 1 | Transmit threshold met |
| rx_thr_flag | output | 1 | Receive threshold met |
| undr_flag | output | 1 | Sticky underrun |
| ovr_flag | output | 1 | Sticky overrun |
| end_flag | output | 1 | Transfer finished |
| loop_en | output | 1 | Loopback select to the shift logic |
| irq | output | 1 | Combined interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The hardest state to reach is a full receive queue meeting other events in the same cycle. These events are an engine write with no host read (overrun and a discarded word), an engine write with a host read (both complete), and a set of the overrun flag coinciding with a software clear. The stimulus fills the receive queue to exactly 16 through the engine port, then issues these combinations one cycle at a time. It then drains the queue to confirm which words survived. The same approach empties the transmit queue and keeps the engine reading, which drives the underrun path. In that state it also lowers `unit_en`, to show that neither flag moves.

// File: rtl/sfs_pkg.sv
// Shared constants, types and the threshold-code decoder for the serial
// FIFO status unit. Assumes thresholds never exceed the queue depth.
package sfs_pkg;
    localparam int DATA_W = 17;
    localparam int DEPTH  = 16;

    typedef logic [1:0] thr_code_t;

    // Map a 2-bit threshold code onto a word level.
    function automatic int unsigned thr_level(thr_code_t code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/sfs_fifo.sv
// Synchronous first-in first-out queue with flush, occupancy count and
// a zero head when empty. Assumes DEPTH is a power of two. A push to a
// full queue is accepted only when a pop in the same cycle frees a slot.
// Flush overrides push and pop.
module sfs_fifo #(
    parameter int DATA_W = 17,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              push_acc
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              pop_ok;

    // Derive status and the accept decisions for this cycle.
    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        pop_ok   = pop && !empty;
        push_acc = push && (!full || pop_ok);
        head     = empty ? '0 : mem[rd_ptr];
    end

    // Advance pointers and count on accepted operations or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)   rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_acc) - CW'(pop_ok);
        end
    end

    // Store an accepted word; the array itself needs no reset.
    always_ff @(posedge clk) begin
        if (push_acc && !flush) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/sfs_flags.sv
// Threshold comparison, sticky error flags, interrupt combining and DMA
// requests. Assumes the counts come straight from the two queues. A set
// of an error flag wins over a clear in the same cycle.
module sfs_flags #(
    parameter int CW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   tx_count,
    input  logic [CW-1:0]   rx_count,
    input  sfs_pkg::thr_code_t tx_thr_code,
    input  sfs_pkg::thr_code_t rx_thr_code,
    input  logic            undr_set,
    input  logic            ovr_set,
    input  logic            clr_wr,
    input  logic [1:0]      clr_data,
    input  logic            ie_tx_thr,
    input  logic            ie_rx_thr,
    input  logic            ie_undr,
    input  logic            ie_ovr,
    input  logic            dma_en,
    output logic            tx_thr_flag,
    output logic            rx_thr_flag,
    output logic            undr_flag,
    output logic            ovr_flag,
    output logic            irq,
    output logic            dma_tx_req,
    output logic            dma_rx_req
);
    logic [3:0] src, ena;

    // Compare occupancies against the decoded levels.
    always_comb begin
        tx_thr_flag = (32'(tx_count) <= sfs_pkg::thr_level(tx_thr_code));
        rx_thr_flag = (32'(rx_count) >= sfs_pkg::thr_level(rx_thr_code));
    end

    // Hold error flags until a zero is written; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undr_flag <= 1'b0;
            ovr_flag  <= 1'b0;
        end else begin
            if (undr_set)                      undr_flag <= 1'b1;
            else if (clr_wr && !clr_data[1])   undr_flag <= 1'b0;
            if (ovr_set)                       ovr_flag  <= 1'b1;
            else if (clr_wr && !clr_data[0])   ovr_flag  <= 1'b0;
        end
    end

    // Mask and merge the sources; DMA takes threshold flags left unmasked.
    always_comb begin
        src        = {ovr_flag, undr_flag, rx_thr_flag, tx_thr_flag};
        ena        = {ie_ovr, ie_undr, ie_rx_thr, ie_tx_thr};
        irq        = |(src & ena);
        dma_tx_req = dma_en && !ie_tx_thr && tx_thr_flag;
        dma_rx_req = dma_en && !ie_rx_thr && rx_thr_flag;
    end
endmodule

// File: rtl/sfs_unit.sv
// Top of the serial FIFO status unit: two queues, the flag logic, and
// gating of the engine-side ports by the unit enable. Assumes the host
// and engine ports are single-cycle strobes in the clk domain.
module sfs_unit #(
    parameter int DATA_W = sfs_pkg::DATA_W,
    parameter int DEPTH  = sfs_pkg::DEPTH,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unit_en,
    input  logic              loop_cfg,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              tx_flush,
    input  logic              rx_flush,
    input  logic              err_clr_wr,
    input  logic [1:0]        err_clr_data,
    input  logic [1:0]        tx_thr_code,
    input  logic [1:0]        rx_thr_code,
    input  logic              ie_tx_thr,
    input  logic              ie_rx_thr,
    input  logic              ie_undr,
    input  logic              ie_ovr,
    input  logic              dma_en,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic [CW-1:0]     tx_count,
    output logic [CW-1:0]     rx_count,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              tx_thr_flag,
    output logic              rx_thr_flag,
    output logic              undr_flag,
    output logic              ovr_flag,
    output logic              end_flag,
    output logic              loop_en,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    logic eng_pop_g, eng_push_g;
    logic tx_empty, rx_full, tx_acc_unused, rx_acc;
    logic undr_set, ovr_set;

    // Gate engine strobes and form the error events.
    always_comb begin
        eng_pop_g  = unit_en && eng_tx_pop;
        eng_push_g = unit_en && eng_rx_push;
        undr_set   = eng_pop_g && tx_empty;
        ovr_set    = eng_push_g && !rx_acc && !rx_flush;
        end_flag   = !eng_busy;
        loop_en    = unit_en && loop_cfg;
    end

    sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(host_push), .wdata(host_wdata), .pop(eng_pop_g),
        .head(eng_tx_data), .count(tx_count), .full(tx_full),
        .empty(tx_empty), .push_acc(tx_acc_unused)
    );

    sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_push_g), .wdata(eng_rx_data), .pop(host_pop),
        .head(host_rdata), .count(rx_count), .full(rx_full),
        .empty(rx_empty), .push_acc(rx_acc)
    );

    sfs_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thr_code(tx_thr_code), .rx_thr_code(rx_thr_code),
        .undr_set(undr_set), .ovr_set(ovr_set),
        .clr_wr(err_clr_wr), .clr_data(err_clr_data),
        .ie_tx_thr(ie_tx_thr), .ie_rx_thr(ie_rx_thr),
        .ie_undr(ie_undr), .ie_ovr(ie_ovr), .dma_en(dma_en),
        .tx_thr_flag(tx_thr_flag), .rx_thr_flag(rx_thr_flag),
        .undr_flag(undr_flag), .ovr_flag(ovr_flag), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );
endmodule

// File: rtl/sfs_checker.sv
// Port-level properties for sfs_unit, attached by bind. Assumes the
// synchronous active-low reset of the unit.
module sfs_checker #(
    parameter int DATA_W = 17,
    parameter int CW     = 5,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              unit_en,
    input logic              host_pop,
    input logic [DATA_W-1:0] host_rdata,
    input logic              tx_flush,
    input logic              rx_flush,
    input logic              err_clr_wr,
    input logic [1:0]        err_clr_data,
    input logic              ie_tx_thr,
    input logic              ie_rx_thr,
    input logic              ie_undr,
    input logic              ie_ovr,
    input logic              eng_tx_pop,
    input logic              eng_rx_push,
    input logic [CW-1:0]     tx_count,
    input logic [CW-1:0]     rx_count,
    input logic              undr_flag,
    input logic              ovr_flag,
    input logic              irq,
    input logic              dma_tx_req,
    input logic              dma_rx_req
);
    AST_TX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH)); // R1
    AST_UNDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        undr_flag && !(err_clr_wr && !err_clr_data[1]) |=> undr_flag); // R4
    AST_UNDR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en && eng_tx_pop && tx_count == '0 |=> undr_flag); // R4
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en && eng_rx_push && rx_count == CW'(DEPTH) && !host_pop && !rx_flush
        |=> ovr_flag && rx_count == CW'(DEPTH)); // R4
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_wr && !err_clr_data[0] && !eng_rx_push |=> !ovr_flag); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_tx_thr && !ie_rx_thr && !ie_undr && !ie_ovr |-> !irq); // R6
    AST_DMA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_tx_req && ie_tx_thr) && !(dma_rx_req && ie_rx_thr)); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush && rx_flush |=> tx_count == '0 && rx_count == '0); // R9
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == '0 |-> host_rdata == '0); // R10
endmodule

bind sfs_unit sfs_checker #(.DATA_W(DATA_W), .CW(CW), .DEPTH(DEPTH)) u_sfs_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .host_pop(host_pop),
    .host_rdata(host_rdata), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .err_clr_wr(err_clr_wr), .err_clr_data(err_clr_data),
    .ie_tx_thr(ie_tx_thr), .ie_rx_thr(ie_rx_thr), .ie_undr(ie_undr),
    .ie_ovr(ie_ovr), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .tx_count(tx_count), .rx_count(rx_count), .undr_flag(undr_flag),
    .ovr_flag(ovr_flag), .irq(irq), .dma_tx_req(dma_tx_req),
    .dma_rx_req(dma_rx_req)
);

// File: tb/tb_sfs_unit.sv
`timescale 1ns/1ps
module tb_sfs_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unit_en = 1'b1, loop_cfg = 1'b0;
    logic host_push = 1'b0, host_pop = 1'b0;
    logic [16:0] host_wdata = '0, eng_rx_data = '0;
    logic [16:0] host_rdata, eng_tx_data;
    logic tx_flush = 1'b0, rx_flush = 1'b0, err_clr_wr = 1'b0;
    logic [1:0] err_clr_data = 2'b11, tx_thr_code = 2'b10, rx_thr_code = 2'b01;
    logic ie_tx_thr = 1'b0, ie_rx_thr = 1'b0, ie_undr = 1'b0, ie_ovr = 1'b0;
    logic dma_en = 1'b0, eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [4:0] tx_count, rx_count;
    logic tx_full, rx_empty, tx_thr_flag, rx_thr_flag, undr_flag, ovr_flag;
    logic end_flag, loop_en, irq, dma_tx_req, dma_rx_req;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [16:0] txq[$], rxq[$];
    bit m_undr = 0, m_ovr = 0;

    always #10 clk = ~clk;

    sfs_unit dut (.*);

    function automatic int lvl(logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 4 : (c == 2'b10) ? 8 : 14;
    endfunction

    task automatic chk(string what, string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference update from pre-edge inputs.
    task automatic model_step();
        bit tpop, rpush, pop_ok, acc, uset, oset;
        tpop  = unit_en && eng_tx_pop;
        rpush = unit_en && eng_rx_push;
        uset  = tpop && txq.size() == 0;
        oset  = 0;
        if (tx_flush) txq.delete();
        else begin
            pop_ok = tpop && txq.size() > 0;
            acc = host_push && (txq.size() < 16 || pop_ok);
            if (pop_ok) void'(txq.pop_front());
            if (acc) txq.push_back(host_wdata);
        end
        if (rx_flush) rxq.delete();
        else begin
            pop_ok = host_pop && rxq.size() > 0;
            acc = rpush && (rxq.size() < 16 || pop_ok);
            oset = rpush && !acc;
            if (pop_ok) void'(rxq.pop_front());
            if (acc) rxq.push_back(eng_rx_data);
        end
        if (uset) m_undr = 1; else if (err_clr_wr && !err_clr_data[1]) m_undr = 0;
        if (oset) m_ovr = 1;  else if (err_clr_wr && !err_clr_data[0]) m_ovr = 0;
    endtask

    task automatic compare_all();
        int tc, rc;
        bit tt, rt;
        tc = txq.size(); rc = rxq.size();
        tt = tc <= lvl(tx_thr_code);
        rt = rc >= lvl(rx_thr_code);
        chk("tx_count", "R1", tx_count, tc);
        chk("rx_count", "R1", rx_count, rc);
        chk("tx_full", "R1", tx_full, tc == 16);
        chk("rx_empty", "R1", rx_empty, rc == 0);
        chk("tx_thr_flag", "R2", tx_thr_flag, tt);
        chk("rx_thr_flag", "R3", rx_thr_flag, rt);
        chk("undr_flag", "R4", undr_flag, m_undr);
        chk("ovr_flag", "R4", ovr_flag, m_ovr);
        chk("host_rdata", "R10", host_rdata, rc ? rxq[0] : 0);
        chk("eng_tx_data", "R10", eng_tx_data, tc ? txq[0] : 0);
        chk("irq", "R6", irq, (tt && ie_tx_thr) || (rt && ie_rx_thr) ||
                              (m_undr && ie_undr) || (m_ovr && ie_ovr));
        chk("dma_tx_req", "R7", dma_tx_req, dma_en && !ie_tx_thr && tt);
        chk("dma_rx_req", "R7", dma_rx_req, dma_en && !ie_rx_thr && rt);
        chk("end_flag", "R11", end_flag, !eng_busy);
        chk("loop_en", "R11", loop_en, unit_en && loop_cfg);
    endtask

    // One clock: model and DUT step at the edge, compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        host_push = 0; host_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
        tx_flush = 0; rx_flush = 0; err_clr_wr = 0; err_clr_data = 2'b11;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        repeat (2) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset tx_thr", "R8", tx_thr_flag, 1);
        chk("reset rx_empty", "R8", rx_empty, 1);
        chk("reset end", "R8", end_flag, 1);
        chk("reset errors", "R8", {undr_flag, ovr_flag}, 0);
        compare_all();

        // R1 R2: fill tx past full while sweeping the code
        for (int i = 0; i < 18; i++) begin
            host_push = 1; host_wdata = 17'(i * 4099 + 13);
            tx_thr_code = 2'(i);
            cyc();
        end
        // R1: push with engine pop on full is accepted
        host_push = 1; host_wdata = 17'h1abcd; eng_tx_pop = 1; cyc();
        // R7: DMA from thresholds
        dma_en = 1; tx_thr_code = 2'b11;
        for (int i = 0; i < 17; i++) begin
            eng_tx_pop = 1; tx_thr_code = 2'(i); cyc();
        end
        // R4: underrun with extra pops, R6 irq on underrun
        ie_undr = 1; eng_tx_pop = 1; cyc(); eng_tx_pop = 1; cyc();
        // R5: writing ones has no effect, zero clears, set beats clear
        err_clr_wr = 1; err_clr_data = 2'b11; cyc();
        err_clr_wr = 1; err_clr_data = 2'b00; eng_tx_pop = 1; cyc();
        err_clr_wr = 1; err_clr_data = 2'b01; cyc();
        // R3 R4 R12: fill rx, overflow, full push with pop
        ie_rx_thr = 1; ie_ovr = 1;
        for (int i = 0; i < 18; i++) begin
            eng_rx_push = 1; eng_rx_data = 17'(i * 7919 + 5);
            rx_thr_code = 2'(i >> 1);
            cyc();
        end
        eng_rx_push = 1; host_pop = 1; eng_rx_data = 17'h15555; cyc(); // R12
        err_clr_wr = 1; err_clr_data = 2'b10; cyc();                   // R5
        err_clr_wr = 1; err_clr_data = 2'b10; eng_rx_push = 1; cyc();  // R5 set wins
        // R9: unit disabled keeps content and ignores engine
        unit_en = 0; loop_cfg = 1; eng_busy = 1;
        err_clr_wr = 1; err_clr_data = 2'b00; cyc();
        eng_rx_push = 1; eng_tx_pop = 1; cyc();
        eng_rx_push = 1; host_pop = 1; cyc();
        unit_en = 1; cyc();
        // R10: drain rx fully then pop empty
        for (int i = 0; i < 18; i++) begin host_pop = 1; cyc(); end
        // R9: flush overrides push
        host_push = 1; cyc(); host_push = 1; cyc();
        host_push = 1; tx_flush = 1; cyc();
        eng_rx_push = 1; cyc(); eng_rx_push = 1; rx_flush = 1; host_pop = 1; cyc();
        // R6 R7: enable combinations
        for (int i = 0; i < 32; i++) begin
            {ie_tx_thr, ie_rx_thr, ie_undr, ie_ovr, dma_en} = 5'(i);
            eng_busy = i[0]; loop_cfg = i[1];
            if (i[2]) host_push = 1; else eng_rx_push = 1;
            eng_rx_data = 17'(i);
            cyc();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule